// File: doc/BRIEF.md
# Serial ADC Host Reader

This block is the host side of a three-wire link to a 10-bit successive-approximation converter. The link has three lines: an active-low select, a serial clock and a single data line back from the converter. The block starts a transaction when a start request arrives while it is idle. It pulls the select low and waits one phase with the clock held low. It then produces a run-time selectable number of clock pulses, each phase lasting a run-time number of system-clock cycles.

The converter changes its data line after each rising clock edge. The reader samples that line at the end of every high phase. It checks that the first two samples are zero, shifts the next ten in MSB first as the result, and can also keep the two sub-bits that follow. At the end of the frame it raises the select, strobes the result and holds off new starts for a minimum recovery time.

An abort input ends a frame early. After an abort the select rises at once and no result is strobed. A longer recovery wait, sized for input acquisition, is then enforced. Start requests that arrive while a frame or a recovery wait is running are dropped, and a busy flag covers that whole span.

Top module: `sadc_reader`

## Requirements
- R1: While reset is asserted and after it is released, cs_no is 1, and sclk_o, busy_o and valid_o are 0.
- R2: A start_i sampled high in idle makes cs_no fall on the next clock edge, with sclk_o low at that moment. A start_i sampled while busy_o is high is dropped and is not queued.
- R3: A frame with phase length d system cycles consists of one setup phase of d cycles with sclk_o low, then N pulses, each high for d cycles and then low for d cycles. So cs_no stays low for d*(2N+1) cycles. A div_i value of 0 is treated as d = 1; any other value gives d = div_i. div_i and len_sel_i are latched when the start is accepted.
- R4: len_sel_i selects the pulse count N: 0 gives 13, 1 gives 15, and 2 or 3 give 16.
- R5: sdata_i is sampled as the last cycle of each high phase ends. Samples 1 and 2 are leading zeros, and samples 3 through 12 form result_o, with sample 3 as bit 9 and sample 12 as bit 0.
- R6: Samples 13 and 14 form sub_o, with sample 13 as bit 1. This applies only when N is at least 14. For N = 13, sub_o is 0.
- R7: frame_err_o is 1 for a completed frame exactly when sample 1 or sample 2 was 1.
- R8: valid_o is a one-cycle pulse in the first cycle that cs_no is high after the last low phase. result_o, sub_o and frame_err_o are updated only then and hold until the next pulse.
- R9: After a completed frame, cs_no stays high for at least CSHI_CYC+1 cycles, and exactly that many when start_i is held high.
- R10: abort_i sampled high while cs_no is low raises cs_no and forces sclk_o low on the next edge, with no valid_o. cs_no then stays high for at least ACQ_CYC+1 cycles, and exactly that many when start_i is held high.
- R11: busy_o is high from the cycle after an accepted start until the recovery wait has ended, including every cycle with cs_no low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a conversion frame |
| abort_i | input | 1 | End the running frame early |
| div_i | input | DIV_W | Phase length in system cycles (0 treated as 1) |
| len_sel_i | input | 2 | Pulse count select: 13, 15, 16, 16 |
| sdata_i | input | 1 | Serial data from the converter |
| cs_no | output | 1 | Converter select, active low |
| sclk_o | output | 1 | Serial clock to the converter, idles low |
| busy_o | output | 1 | Frame or recovery wait in progress |
| valid_o | output | 1 | One-cycle result strobe |
| result_o | output | RES_W | Captured conversion result |
| sub_o | output | SUB_W | Captured sub-bits |
| frame_err_o | output | 1 | A leading bit read back as 1 |

## Verification
The bench builds the reader with DIV_W = 4, CSHI_CYC = 4 and ACQ_CYC = 12. These short waits let the exact select-high spans after normal and aborted frames be counted cycle for cycle. The phase lengths used are 1, 2 and 3, plus the zero setting, so the full select-low length d*(2N+1) is checked for every pulse count. A behavioural converter in the bench can drive ones into the leading positions, which exercises the framing check alongside normal frames.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_HIGH,
    ST_LOW,
    ST_REC
  } sadc_st_e;
endpackage

// File: rtl/sadc_tick.sv
// Phase timer: pulses tick_o on the last cycle of each lim_i-cycle phase.
module sadc_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] lim_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == lim_i - DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/sadc_capture.sv
// Sorts sample slots into leading check, result and sub-bit fields.
module sadc_capture #(
  parameter int RES_W  = 10,
  parameter int LEAD_N = 2,
  parameter int SUB_W  = 2,
  parameter int EDGE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              sample_i,
  input  logic [EDGE_W-1:0] idx_i,
  input  logic              sdata_i,
  output logic [RES_W-1:0]  res_o,
  output logic [SUB_W-1:0]  sub_o,
  output logic              err_o
);
  localparam logic [EDGE_W-1:0] LEAD_END = EDGE_W'(LEAD_N);
  localparam logic [EDGE_W-1:0] RES_END  = EDGE_W'(LEAD_N + RES_W);
  localparam logic [EDGE_W-1:0] SUB_END  = EDGE_W'(LEAD_N + RES_W + SUB_W);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o <= '0;
      sub_o <= '0;
      err_o <= 1'b0;
    end else if (clear_i) begin
      res_o <= '0;
      sub_o <= '0;
      err_o <= 1'b0;
    end else if (sample_i) begin
      if (idx_i <= LEAD_END)     err_o <= err_o | sdata_i;
      else if (idx_i <= RES_END) res_o <= {res_o[RES_W-2:0], sdata_i};
      else if (idx_i <= SUB_END) sub_o <= {sub_o[SUB_W-2:0], sdata_i};
    end
  end
endmodule

// File: rtl/sadc_wait.sv
// Recovery down-counter; done_o once it reaches zero.
module sadc_wait #(
  parameter int WAIT_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WAIT_W-1:0] val_i,
  input  logic              en_i,
  output logic              done_o
);
  logic [WAIT_W-1:0] cnt_q;

  assign done_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= val_i;
    else if (en_i && !done_o)  cnt_q <= cnt_q - WAIT_W'(1);
  end
endmodule

// File: rtl/sadc_reader.sv
module sadc_reader
  import sadc_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int CSHI_CYC = 7,
  parameter int ACQ_CYC  = 30,
  parameter int RES_W    = 10,
  parameter int LEAD_N   = 2,
  parameter int SUB_W    = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [1:0]       len_sel_i,
  input  logic             sdata_i,
  output logic             cs_no,
  output logic             sclk_o,
  output logic             busy_o,
  output logic             valid_o,
  output logic [RES_W-1:0] result_o,
  output logic [SUB_W-1:0] sub_o,
  output logic             frame_err_o
);
  localparam int LEN_BASE = LEAD_N + RES_W + 1;
  localparam int LEN_MAX  = LEN_BASE + 3;
  localparam int EDGE_W   = $clog2(LEN_MAX + 1);
  localparam int WAIT_MAX = (CSHI_CYC > ACQ_CYC) ? CSHI_CYC : ACQ_CYC;
  localparam int WAIT_W   = $clog2(WAIT_MAX + 1);
  localparam logic [EDGE_W-1:0] SUB_LEN = EDGE_W'(LEAD_N + RES_W + SUB_W);

  sadc_st_e          st_q;
  logic [DIV_W-1:0]  div_q;
  logic [EDGE_W-1:0] len_q, edge_q;
  logic              tick, in_frame, abort_hit, finish, accept;
  logic              wait_load, wait_done;
  logic [WAIT_W-1:0] wait_val;
  logic [RES_W-1:0]  cap_res;
  logic [SUB_W-1:0]  cap_sub;
  logic              cap_err;

  function automatic logic [EDGE_W-1:0] frame_len(input logic [1:0] sel);
    case (sel)
      2'd0:    return EDGE_W'(LEN_BASE);
      2'd1:    return EDGE_W'(LEN_BASE + 2);
      default: return EDGE_W'(LEN_BASE + 3);
    endcase
  endfunction

  assign in_frame  = (st_q == ST_SETUP) || (st_q == ST_HIGH) || (st_q == ST_LOW);
  assign accept    = (st_q == ST_IDLE) && start_i;
  assign abort_hit = in_frame && abort_i;
  assign finish    = (st_q == ST_LOW) && tick && !abort_i && (edge_q == len_q);
  assign wait_load = abort_hit || finish;
  assign wait_val  = abort_hit ? WAIT_W'(ACQ_CYC - 1) : WAIT_W'(CSHI_CYC - 1);

  sadc_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (in_frame),
    .lim_i  (div_q),
    .tick_o (tick)
  );

  sadc_capture #(
    .RES_W  (RES_W),
    .LEAD_N (LEAD_N),
    .SUB_W  (SUB_W),
    .EDGE_W (EDGE_W)
  ) u_capture (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (accept),
    .sample_i ((st_q == ST_HIGH) && tick && !abort_i),
    .idx_i    (edge_q),
    .sdata_i  (sdata_i),
    .res_o    (cap_res),
    .sub_o    (cap_sub),
    .err_o    (cap_err)
  );

  sadc_wait #(.WAIT_W(WAIT_W)) u_wait (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (wait_load),
    .val_i  (wait_val),
    .en_i   (st_q == ST_REC),
    .done_o (wait_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      div_q  <= DIV_W'(1);
      len_q  <= EDGE_W'(LEN_BASE);
      edge_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start_i) begin
          div_q  <= (div_i == '0) ? DIV_W'(1) : div_i;
          len_q  <= frame_len(len_sel_i);
          edge_q <= EDGE_W'(1);
          st_q   <= ST_SETUP;
        end
        ST_SETUP: begin
          if (abort_i)   st_q <= ST_REC;
          else if (tick) st_q <= ST_HIGH;
        end
        ST_HIGH: begin
          if (abort_i)   st_q <= ST_REC;
          else if (tick) st_q <= ST_LOW;
        end
        ST_LOW: begin
          if (abort_i) st_q <= ST_REC;
          else if (tick) begin
            if (edge_q == len_q) st_q <= ST_REC;
            else begin
              edge_q <= edge_q + EDGE_W'(1);
              st_q   <= ST_HIGH;
            end
          end
        end
        ST_REC:  if (wait_done) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      result_o    <= '0;
      sub_o       <= '0;
      frame_err_o <= 1'b0;
    end else begin
      valid_o <= finish;
      if (finish) begin
        result_o    <= cap_res;
        sub_o       <= (len_q >= SUB_LEN) ? cap_sub : '0;
        frame_err_o <= cap_err;
      end
    end
  end

  assign cs_no  = !in_frame;
  assign sclk_o = (st_q == ST_HIGH);
  assign busy_o = (st_q != ST_IDLE);
endmodule

// File: rtl/sadc_reader_chk.sv
module sadc_reader_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic abort_i,
  input logic cs_no,
  input logic sclk_o,
  input logic busy_o,
  input logic valid_o
);
  // R2
  a_r2_cs_fall_from_idle_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> ($past(start_i) && !$past(busy_o)));
  // R2
  a_r2_sclk_low_at_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> !sclk_o);
  // R3
  a_r3_sclk_inside_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> !cs_no);
  // R11
  a_r11_busy_covers_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_no |-> busy_o);
  // R8
  a_r8_valid_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  // R8
  a_r8_valid_at_cs_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $rose(cs_no));
  // R10
  a_r10_abort_ends_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && abort_i) |=> (cs_no && !sclk_o && !valid_o));
  // R9
  a_r9_cs_high_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |=> cs_no);
endmodule

bind sadc_reader sadc_reader_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .abort_i (abort_i),
  .cs_no   (cs_no),
  .sclk_o  (sclk_o),
  .busy_o  (busy_o),
  .valid_o (valid_o)
);

// File: tb/sadc_reader_bench.sv
module sadc_reader_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W = 4;
  localparam int CSHI = 4;
  localparam int ACQ = 12;
  localparam int WDOG = 100000;

  // {code[18:9], sub[8:7], sel[6:5], div[4:1], bad[0]}
  localparam logic [18:0] VEC [0:5] = '{
    {10'h2A5, 2'b10, 2'd1, 4'd1, 1'b0},
    {10'h3FF, 2'b11, 2'd2, 4'd2, 1'b0},
    {10'h000, 2'b01, 2'd0, 4'd3, 1'b0},
    {10'h155, 2'b01, 2'd3, 4'd1, 1'b0},
    {10'h201, 2'b10, 2'd0, 4'd0, 1'b0},
    {10'h0F0, 2'b11, 2'd1, 4'd2, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, abort_r = 1'b0;
  logic [DIV_W-1:0] div = '0;
  logic [1:0] sel = '0;
  logic sdata = 1'b0;
  logic cs_n, sclk, busy, valid, ferr;
  logic [9:0] res;
  logic [1:0] sub;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int low_cnt = 0, pulse_cnt = 0, valid_cnt = 0;
  logic [9:0] m_code = '0;
  logic [1:0] m_sub = '0;
  logic m_bad = 1'b0;
  int m_edge = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sadc_reader #(.DIV_W(DIV_W), .CSHI_CYC(CSHI), .ACQ_CYC(ACQ)) u_sadc_reader (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .abort_i(abort_r),
    .div_i(div), .len_sel_i(sel), .sdata_i(sdata),
    .cs_no(cs_n), .sclk_o(sclk), .busy_o(busy), .valid_o(valid),
    .result_o(res), .sub_o(sub), .frame_err_o(ferr)
  );

  function automatic logic stream_bit(input int n);
    if (n <= 2)       return m_bad;
    else if (n <= 12) return m_code[12-n];
    else if (n == 13) return m_sub[1];
    else if (n == 14) return m_sub[0];
    else              return 1'b0;
  endfunction

  // behavioural converter
  always @(negedge cs_n) begin m_edge = 0; sdata = m_bad; end
  always @(posedge sclk) begin m_edge++; sdata = stream_bit(m_edge); pulse_cnt++; end
  always @(negedge clk) begin
    cyc++;
    if (!cs_n) low_cnt++;
    if (valid) valid_cnt++;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_valid();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (valid) return;
    end
    check("R8 valid timeout", 0, 1);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000; i++) begin
      if (!busy) return;
      @(negedge clk);
    end
    check("R11 idle timeout", 0, 1);
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    wait (cyc > WDOG);
    check("watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 cs in reset", int'(cs_n), 1);
    check("R1 sclk/busy/valid in reset", int'({sclk, busy, valid}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle after reset", int'({cs_n, sclk, busy, valid}), 8);

    // table-driven frames: R3 R4 R5 R6 R7 R8
    for (int v = 0; v < 6; v++) begin
      int d, n, es;
      m_code = VEC[v][18:9];
      m_sub  = VEC[v][8:7];
      m_bad  = VEC[v][0];
      sel    = VEC[v][6:5];
      div    = VEC[v][4:1];
      d  = (VEC[v][4:1] == 0) ? 1 : int'(VEC[v][4:1]);
      n  = (sel == 2'd0) ? 13 : (sel == 2'd1) ? 15 : 16;
      es = (n >= 14) ? int'(m_sub) : 0;
      low_cnt = 0; pulse_cnt = 0; valid_cnt = 0;
      pulse_start();
      check("R11 busy after start", int'(busy), 1);
      wait_valid();
      check("R5 result", int'(res), int'(m_code));
      check("R6 sub bits", int'(sub), es);
      check("R7 frame error", int'(ferr), int'(m_bad));
      check("R4 pulse count", pulse_cnt, n);
      check("R3 cs low length", low_cnt, d * (2 * n + 1));
      check("R8 cs high at valid", int'(cs_n), 1);
      wait_idle();
      repeat (3) @(negedge clk);
      check("R8 single valid", valid_cnt, 1);
      check("R8 result held", int'(res), int'(m_code));
    end

    // R2 starts during busy are dropped
    m_bad = 1'b0; m_code = 10'h3C3; sel = 2'd0; div = 4'd1;
    valid_cnt = 0;
    pulse_start();
    repeat (4) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_valid();
    @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_idle();
    repeat (10) @(negedge clk);
    check("R2 no queued start", int'({cs_n, busy}), 2);
    check("R2 one frame only", valid_cnt, 1);

    // R9 minimum high time after a normal frame
    begin
      int hi;
      pulse_start();
      wait_valid();
      start = 1'b1;
      hi = 0;
      while (cs_n && hi < 100) begin hi++; @(negedge clk); end
      start = 1'b0;
      check("R9 cs high span", hi, CSHI + 1);
      wait_valid();
      wait_idle();
    end

    // R10 abort mid-frame
    begin
      int hi, vc;
      sel = 2'd2; div = 4'd2;
      pulse_cnt = 0;
      pulse_start();
      while (pulse_cnt < 5) @(negedge clk);
      vc = valid_cnt;
      abort_r = 1'b1; start = 1'b1;
      @(negedge clk);
      abort_r = 1'b0;
      check("R10 cs/sclk after abort", int'({cs_n, sclk}), 2);
      check("R11 busy in recovery", int'(busy), 1);
      hi = 0;
      while (cs_n && hi < 100) begin hi++; @(negedge clk); end
      start = 1'b0;
      check("R10 abort recovery span", hi, ACQ + 1);
      check("R10 no valid on abort", valid_cnt, vc);
      wait_valid();
      wait_idle();
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule